// File: doc/BRIEF.md
# Double-Buffered Serial Peripheral Slave

This block is an 8-bit serial peripheral interface slave. Host logic writes the next byte to send into a transmit holding register, and reads each received byte from a receive holding register. A single shift register between the two holding registers moves one byte per transfer, MSB first. The external clock, data-in and select pins are brought into the system clock domain by two-flop synchronizers. Their edges are detected there.

The four clock modes take idle polarity from mode bit 0 and phase from mode bit 1. In phase 0 (modes 0 and 1) the transmit byte enters the shifter when select falls, so its first bit is on the output before the first leading clock edge. In phase 1 (modes 2 and 3) it enters on the first leading clock edge and input bits are captured on trailing edges. When select stays low between bytes, or a configuration bit holds it low internally, the leading clock edge of each byte opens that byte's transfer. Flags report an empty transmit register, a full receive register, a receive overrun and a transfer in progress.

The controller is a three-state machine:
- `ST_IDLE`: no byte in flight.
- `ST_ARMED`: phase 0, shifter loaded at the select fall, waiting for the first clock.
- `ST_SHIFT`: bits moving.

The transitions are:
- `IDLE→ARMED` on a select fall in phase 0.
- `IDLE→SHIFT` on a leading edge while select is active.
- `ARMED→SHIFT` on a leading edge.
- `SHIFT→IDLE` at the eighth trailing edge.
- Any state `→IDLE` when select goes inactive.

Top module: `spi_dbuf_slave`

## Requirements
- R1: After reset, tx_empty is 1, rx_full is 0, rx_overrun is 0, xfer_busy is 0 and rd_data is 0x00.
- R2: mode[0] gives the idle level of spi_sck and mode[1] gives the phase. In phase 0 a bit is output before its leading edge and captured on that edge. In phase 1 a bit is output on the leading edge and captured on the trailing edge. Every mode moves 8 bits MSB first in both directions.
- R3: In phase 0 the shifter is loaded from the transmit register when select falls. xfer_busy is high from that point until the received byte lands in the receive register.
- R4: In phase 1 the shifter is loaded on the first leading edge, with no load at the select fall. xfer_busy is high from that edge until the received byte lands.
- R5: With select held low across several bytes, the leading edge of each byte starts it. The shifter then takes whatever the transmit register holds at that moment.
- R6: With force_sel set, spi_ss_n is ignored and transfers run as if select were low.
- R7: tx_empty goes to 1 when the transmit register is copied into the shifter, and to 0 when wr_en writes it.
- R8: If tx_empty is 1 when the shifter loads, the byte sent is 0xFF.
- R9: Each completed byte sets rx_full and appears on rd_data. A rd_en pulse clears rx_full.
- R10: A byte completing while rx_full is 1 sets rx_overrun and replaces the receive register with the newer byte. rd_en clears rx_overrun.
- R11: Select going inactive mid-byte abandons the byte: xfer_busy drops and the receive register and rx_full are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | Bit 0 idle clock level, bit 1 clock phase |
| force_sel | input | 1 | Treat select as permanently active |
| spi_sck | input | 1 | Serial clock from master |
| spi_mosi | input | 1 | Serial data from master |
| spi_ss_n | input | 1 | Active-low select from master |
| spi_miso | output | 1 | Serial data to master |
| wr_en | input | 1 | Write pulse for transmit register |
| wr_data | input | 8 | Byte to transmit |
| rd_en | input | 1 | Read pulse, acknowledges receive register |
| rd_data | output | 8 | Receive register contents |
| tx_empty | output | 1 | Transmit register has been consumed |
| rx_full | output | 1 | Unread byte in receive register |
| rx_overrun | output | 1 | A byte replaced an unread one |
| xfer_busy | output | 1 | Transfer in progress |

## Verification
Each of the four modes runs one byte framed by its own select pulse. The bench exchanges distinct patterns both ways, so a reversed bit order or a capture on the wrong edge shows as a wrong byte. Checking xfer_busy and tx_empty just after the select fall separates the load point of phase 0 from that of phase 1. Back-to-back bytes with select held low, and with select forced, show that the leading edge restarts the shifter with the newly written byte. An unwritten transmit register, a missed read and a select pulled mid-byte probe the 0xFF fill, the overrun and the abort.

// File: rtl/spi_dbuf_pkg.sv
package spi_dbuf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_SHIFT = 2'd2
    } xfer_state_t;

endpackage

// File: rtl/spi_sync_in.sv
module spi_sync_in #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cpol,
    input  logic force_sel,
    input  logic sck_raw,
    input  logic mosi_raw,
    input  logic ss_n_raw,
    output logic mosi_s,
    output logic sel_act,
    output logic sel_start,
    output logic lead_edge,
    output logic trail_edge
);
    localparam int NPIN = 3;
    localparam logic [NPIN-1:0] RST_VAL = 3'b100;

    logic [NPIN-1:0] pins;
    logic [NPIN-1:0] stage [STAGES];
    logic            sck_d;
    logic            ssn_d;

    assign pins = {ss_n_raw, mosi_raw, sck_raw};

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage[g] <= RST_VAL;
                    else        stage[g] <= pins;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage[g] <= RST_VAL;
                    else        stage[g] <= stage[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
            ssn_d <= 1'b1;
        end else begin
            sck_d <= stage[STAGES-1][0];
            ssn_d <= stage[STAGES-1][2];
        end
    end

    logic sck_rise, sck_fall;
    assign sck_rise   = stage[STAGES-1][0] & ~sck_d;
    assign sck_fall   = ~stage[STAGES-1][0] & sck_d;
    assign lead_edge  = cpol ? sck_fall : sck_rise;
    assign trail_edge = cpol ? sck_rise : sck_fall;
    assign mosi_s     = stage[STAGES-1][1];
    assign sel_act    = force_sel | ~stage[STAGES-1][2];
    assign sel_start  = ~force_sel & ssn_d & ~stage[STAGES-1][2];

endmodule

// File: rtl/spi_buf_regs.sv
module spi_buf_regs #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic             load,
    input  logic             done,
    input  logic [WIDTH-1:0] rx_byte,
    output logic [WIDTH-1:0] tx_src,
    output logic [WIDTH-1:0] rx_buf,
    output logic             tx_empty,
    output logic             rx_full,
    output logic             overrun
);
    logic [WIDTH-1:0] tx_buf;

    assign tx_src = tx_empty ? {WIDTH{1'b1}} : tx_buf;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_buf   <= '0;
            tx_empty <= 1'b1;
        end else if (wr_en) begin
            tx_buf   <= wr_data;
            tx_empty <= 1'b0;
        end else if (load) begin
            tx_empty <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_buf  <= '0;
            rx_full <= 1'b0;
            overrun <= 1'b0;
        end else if (done) begin
            rx_buf  <= rx_byte;
            rx_full <= 1'b1;
            overrun <= (rx_full & ~rd_en) | (overrun & ~rd_en);
        end else if (rd_en) begin
            rx_full <= 1'b0;
            overrun <= 1'b0;
        end
    end

endmodule

// File: rtl/spi_shift_fsm.sv
module spi_shift_fsm
    import spi_dbuf_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpha,
    input  logic             sel_act,
    input  logic             sel_start,
    input  logic             lead_edge,
    input  logic             trail_edge,
    input  logic             mosi_s,
    input  logic [WIDTH-1:0] tx_src,
    output logic             load,
    output logic             done,
    output logic [WIDTH-1:0] rx_byte,
    output logic             miso,
    output logic             busy
);
    localparam int CW = $clog2(WIDTH);
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    xfer_state_t      state, state_nx;
    logic [WIDTH-1:0] shreg;
    logic [CW-1:0]    cnt;
    logic             samp;
    logic             last_bit;

    assign last_bit = trail_edge && (cnt == LAST);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (sel_act && !cpha && sel_start) state_nx = ST_ARMED;
                else if (sel_act && lead_edge)     state_nx = ST_SHIFT;
            end
            ST_ARMED: begin
                if (!sel_act)       state_nx = ST_IDLE;
                else if (lead_edge) state_nx = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (!sel_act || last_bit) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        load    = (state == ST_IDLE) && sel_act &&
                  ((!cpha && sel_start) || lead_edge);
        done    = (state == ST_SHIFT) && sel_act && last_bit;
        busy    = (state != ST_IDLE);
        miso    = busy ? shreg[WIDTH-1] : tx_src[WIDTH-1];
        rx_byte = cpha ? {shreg[WIDTH-2:0], mosi_s} : {shreg[WIDTH-2:0], samp};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            cnt   <= '0;
            samp  <= 1'b0;
        end else if (load) begin
            shreg <= tx_src;
            cnt   <= '0;
            if (!cpha && lead_edge) samp <= mosi_s;
        end else if (state == ST_ARMED) begin
            if (lead_edge) samp <= mosi_s;
        end else if (state == ST_SHIFT) begin
            if (!cpha) begin
                if (lead_edge) samp <= mosi_s;
                if (trail_edge) begin
                    shreg <= {shreg[WIDTH-2:0], samp};
                    cnt   <= cnt + 1'b1;
                end
            end else begin
                if (lead_edge) shreg <= {shreg[WIDTH-2:0], samp};
                if (trail_edge) begin
                    samp <= mosi_s;
                    cnt  <= cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/spi_dbuf_slave.sv
module spi_dbuf_slave #(
    parameter int WIDTH      = 8,
    parameter int SYNC_STAGE = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic             force_sel,
    input  logic             spi_sck,
    input  logic             spi_mosi,
    input  logic             spi_ss_n,
    output logic             spi_miso,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             tx_empty,
    output logic             rx_full,
    output logic             rx_overrun,
    output logic             xfer_busy
);
    logic             mosi_s, sel_act, sel_start, lead_edge, trail_edge;
    logic             load_p, done_p;
    logic [WIDTH-1:0] rx_byte, tx_src;

    spi_sync_in #(.STAGES(SYNC_STAGE)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpol       (mode[0]),
        .force_sel  (force_sel),
        .sck_raw    (spi_sck),
        .mosi_raw   (spi_mosi),
        .ss_n_raw   (spi_ss_n),
        .mosi_s     (mosi_s),
        .sel_act    (sel_act),
        .sel_start  (sel_start),
        .lead_edge  (lead_edge),
        .trail_edge (trail_edge)
    );

    spi_shift_fsm #(.WIDTH(WIDTH)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpha       (mode[1]),
        .sel_act    (sel_act),
        .sel_start  (sel_start),
        .lead_edge  (lead_edge),
        .trail_edge (trail_edge),
        .mosi_s     (mosi_s),
        .tx_src     (tx_src),
        .load       (load_p),
        .done       (done_p),
        .rx_byte    (rx_byte),
        .miso       (spi_miso),
        .busy       (xfer_busy)
    );

    spi_buf_regs #(.WIDTH(WIDTH)) u_bufs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .load     (load_p),
        .done     (done_p),
        .rx_byte  (rx_byte),
        .tx_src   (tx_src),
        .rx_buf   (rd_data),
        .tx_empty (tx_empty),
        .rx_full  (rx_full),
        .overrun  (rx_overrun)
    );

endmodule

// File: rtl/spi_dbuf_slave_chk.sv
module spi_dbuf_slave_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic             load_p,
    input logic             done_p,
    input logic             sel_act,
    input logic [WIDTH-1:0] rx_byte,
    input logic [WIDTH-1:0] rd_data,
    input logic             tx_empty,
    input logic             rx_full,
    input logic             rx_overrun,
    input logic             xfer_busy,
    input logic             spi_miso
);
    p_load_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load_p && !wr_en |=> tx_empty);

    p_write_fills_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !tx_empty);

    p_fill_ones_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load_p && tx_empty && !wr_en |=> spi_miso);

    p_rx_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_p && !rd_en |=> rx_full && (rd_data == $past(rx_byte)));

    p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !done_p |=> !rx_full);

    p_overrun_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_p && rx_full && !rd_en |=> rx_overrun);

    p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_act |=> !xfer_busy);

    p_busy_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_busy) |-> $past(load_p));

endmodule

bind spi_dbuf_slave spi_dbuf_slave_chk #(.WIDTH(WIDTH)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .load_p     (load_p),
    .done_p     (done_p),
    .sel_act    (sel_act),
    .rx_byte    (rx_byte),
    .rd_data    (rd_data),
    .tx_empty   (tx_empty),
    .rx_full    (rx_full),
    .rx_overrun (rx_overrun),
    .xfer_busy  (xfer_busy),
    .spi_miso   (spi_miso)
);

// File: tb/spi_dbuf_slave_tb_top.sv
module spi_dbuf_slave_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'd0;
    logic       force_sel = 1'b0;
    logic       spi_sck = 1'b0;
    logic       spi_mosi = 1'b0;
    logic       spi_ss_n = 1'b1;
    logic       spi_miso;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       tx_empty, rx_full, rx_overrun, xfer_busy;

    int n_chk = 0;
    int n_fail = 0;
    bit done_flag = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_dbuf_slave dut_i (
        .clk(clk), .rst_n(rst_n), .mode(mode), .force_sel(force_sel),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_ss_n(spi_ss_n),
        .spi_miso(spi_miso), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .tx_empty(tx_empty),
        .rx_full(rx_full), .rx_overrun(rx_overrun), .xfer_busy(xfer_busy)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_mode(input logic [1:0] m);
        mode    = m;
        spi_sck = m[0];
        wait_clk(HALF);
    endtask

    task automatic host_write(input logic [7:0] d);
        @(negedge clk);
        wr_data = d;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic host_read();
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // One full byte as a master; nbits < 8 stops early (for aborts).
    task automatic master_byte(input logic [7:0] mo, input int nbits, output logic [7:0] mi);
        logic cpol, cpha;
        cpol = mode[0];
        cpha = mode[1];
        mi = 8'h00;
        for (int i = 7; i >= 8 - nbits; i--) begin
            if (!cpha) begin
                spi_mosi = mo[i];
                wait_clk(HALF);
                mi[i] = spi_miso;
                spi_sck = ~cpol;
                wait_clk(HALF);
                spi_sck = cpol;
            end else begin
                spi_sck = ~cpol;
                wait_clk(HALF/2);
                spi_mosi = mo[i];
                wait_clk(HALF/2);
                mi[i] = spi_miso;
                spi_sck = cpol;
                wait_clk(HALF);
            end
        end
        wait_clk(6);
    endtask

    task automatic t_reset();
        chk("R1 tx_empty", {7'd0, tx_empty}, 8'h01);
        chk("R1 rx_full", {7'd0, rx_full}, 8'h00);
        chk("R1 overrun", {7'd0, rx_overrun}, 8'h00);
        chk("R1 busy", {7'd0, xfer_busy}, 8'h00);
        chk("R1 rd_data", rd_data, 8'h00);
    endtask

    task automatic t_mode(input logic [1:0] m);
        logic [7:0] tx, rx, got;
        tx = 8'hA5 ^ {6'd0, m};
        rx = 8'h3C + {6'd0, m};
        set_mode(m);
        host_write(tx);
        chk("R7 write clears empty", {7'd0, tx_empty}, 8'h00);
        spi_ss_n = 1'b0;
        wait_clk(6);
        if (!m[1]) begin
            chk("R3 busy at select fall", {7'd0, xfer_busy}, 8'h01);
            chk("R3 load at select fall", {7'd0, tx_empty}, 8'h01);
        end else begin
            chk("R4 idle before first edge", {7'd0, xfer_busy}, 8'h00);
            chk("R4 no load at select fall", {7'd0, tx_empty}, 8'h00);
        end
        master_byte(rx, 8, got);
        chk("R2 master receives", got, tx);
        chk("R2 slave receives", rd_data, rx);
        chk("R9 rx_full set", {7'd0, rx_full}, 8'h01);
        chk("R3 R4 busy ends at rx load", {7'd0, xfer_busy}, 8'h00);
        chk("R7 empty after load", {7'd0, tx_empty}, 8'h01);
        spi_ss_n = 1'b1;
        wait_clk(HALF);
        host_read();
        chk("R9 read clears rx_full", {7'd0, rx_full}, 8'h00);
    endtask

    task automatic t_held(input logic [1:0] m);
        logic [7:0] got;
        set_mode(m);
        host_write(8'h81);
        spi_ss_n = 1'b0;
        wait_clk(HALF);
        master_byte(8'h5A, 8, got);
        chk("R5 first byte out", got, 8'h81);
        chk("R5 first byte in", rd_data, 8'h5A);
        host_read();
        host_write(8'h42);
        wait_clk(4);
        master_byte(8'hC3, 8, got);
        chk("R5 second byte out", got, 8'h42);
        chk("R5 second byte in", rd_data, 8'hC3);
        host_read();
        spi_ss_n = 1'b1;
        wait_clk(HALF);
    endtask

    task automatic t_force();
        logic [7:0] got;
        set_mode(2'd1);
        force_sel = 1'b1;
        wait_clk(4);
        host_write(8'h96);
        wait_clk(4);
        master_byte(8'h69, 8, got);
        chk("R6 forced out", got, 8'h96);
        chk("R6 forced in", rd_data, 8'h69);
        host_read();
        force_sel = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic t_empty();
        logic [7:0] got;
        set_mode(2'd0);
        chk("R8 starts empty", {7'd0, tx_empty}, 8'h01);
        spi_ss_n = 1'b0;
        wait_clk(HALF);
        master_byte(8'h12, 8, got);
        chk("R8 sends ones", got, 8'hFF);
        spi_ss_n = 1'b1;
        wait_clk(HALF);
        host_read();
    endtask

    task automatic t_overrun();
        logic [7:0] got;
        set_mode(2'd2);
        spi_ss_n = 1'b0;
        wait_clk(HALF);
        master_byte(8'h11, 8, got);
        chk("R10 no overrun yet", {7'd0, rx_overrun}, 8'h00);
        master_byte(8'hE7, 8, got);
        chk("R10 overrun set", {7'd0, rx_overrun}, 8'h01);
        chk("R10 newer byte kept", rd_data, 8'hE7);
        host_read();
        chk("R10 read clears overrun", {7'd0, rx_overrun}, 8'h00);
        spi_ss_n = 1'b1;
        wait_clk(HALF);
    endtask

    task automatic t_abort();
        logic [7:0] got;
        set_mode(2'd0);
        host_write(8'h0F);
        spi_ss_n = 1'b0;
        wait_clk(HALF);
        master_byte(8'hAA, 3, got);
        spi_ss_n = 1'b1;
        wait_clk(HALF);
        chk("R11 busy dropped", {7'd0, xfer_busy}, 8'h00);
        chk("R11 rx_full untouched", {7'd0, rx_full}, 8'h00);
        chk("R11 rx buffer untouched", rd_data, 8'hE7);
        host_write(8'hB4);
        spi_ss_n = 1'b0;
        wait_clk(HALF);
        master_byte(8'h2D, 8, got);
        chk("R11 next byte out", got, 8'hB4);
        chk("R11 next byte in", rd_data, 8'h2D);
        spi_ss_n = 1'b1;
        wait_clk(HALF);
        host_read();
    endtask

    initial begin
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(4);
        t_reset();
        for (int m = 0; m < 4; m++) t_mode(m[1:0]);
        t_held(2'd0);
        t_held(2'd3);
        t_force();
        t_empty();
        t_overrun();
        t_abort();
        done_flag = 1'b1;
    end

    initial begin
        fork
            wait (done_flag);
            begin
                repeat (150000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule